// File: doc/BRIEF.md
# Strobe-Triggered Sample Capture Buffer

This block records bytes from an 8-bit parallel input into a 32-entry on-chip store. A separate, asynchronous data-valid strobe announces each new byte: the block brings the strobe into its clock domain, finds its rising edges and stores one byte per edge. The first byte goes to entry 0, and each later byte goes to the next entry.

When the last entry has been written, a sticky full flag goes high. After that point the store is frozen and strobes are ignored until the next reset. A synchronous read port lets the surrounding logic inspect any entry, one cycle after the address is presented.

The data input has no back-pressure. The producer signals each byte only by raising the strobe, and there is no ready path towards it. The producer must hold the byte stable through the capture edge defined in R3.

Top module: `strobe_capture_buf`

## Requirements
- R1: While `rst_ni` is low, and until the first capture after it is released, `full_o` reads 0 and every entry reads back as 8'h00.
- R2: One rising edge of `strobe_i` stores exactly one byte, however many cycles the strobe stays high.
- R3: Suppose `strobe_i` first reads high at clock edge E0. The byte stored is the value `data_i` has at clock edge E3, so changes to `data_i` before or after E3 do not affect the stored value.
- R4: Captures are written to consecutive entries, starting at entry 0 after reset and continuing up to entry 31.
- R5: `full_o` rises at the clock edge that writes the 32nd byte, which is edge E3 of that capture. Until reset, it then stays high.
- R6: While `full_o` is high, strobe edges change no entry and do not move the write position.
- R7: If `rd_addr_i` is presented before clock edge K, `rd_data_o` shows that entry after K. When the same edge K also writes that entry, `rd_data_o` shows the value held before the write, and the new value appears one edge later.
- R8: A reset clears `full_o` and the store, and the next capture after reset lands in entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Asynchronous data-valid strobe; a rising edge requests a capture |
| data_i | input | 8 | Parallel byte to be captured |
| full_o | output | 1 | Sticky flag: all 32 entries are written |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 8 | Entry at the read address, registered |

## Verification
Two functions can fall in the same clock edge: a capture writes an entry, and the read port samples that same entry. The bench sets up this collision on the first capture after reset. It sets `rd_addr_i` to entry 0 while it raises the strobe, so the read and the write meet at E3. The test passes if `rd_data_o` shows the cleared value just after E3 and the captured byte one edge later. The 32nd capture is a second coincidence, because it writes an entry and raises `full_o` at the same edge, and the bench checks `full_o` on both sides of that edge.

// File: rtl/cap_pkg.sv
package cap_pkg;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned DEPTH  = 32;
  parameter int unsigned SYNC_N = 2;
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  strobe_sync_i,
  output logic  wr_en_o,
  output addr_t wr_addr_o,
  output logic  full_o
);
  localparam addr_t LAST = addr_t'(DEPTH - 1);

  logic  prev_q, take_q, full_q;
  addr_t idx_q;
  logic  edge_w;

  assign edge_w = strobe_sync_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      prev_q <= strobe_sync_i;
      take_q <= edge_w & ~full_q;
    end
  end

  assign wr_en_o   = take_q & ~full_q;
  assign wr_addr_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (wr_en_o) begin
      idx_q <= idx_q + addr_t'(1);
      if (idx_q == LAST) full_q <= 1'b1;
    end
  end

  assign full_o = full_q;

  // R2: a detected edge yields a single write request, never two in a row
  p_single_take_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_q |=> !take_q);
  // R4: each write moves the position by exactly one
  p_idx_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> (idx_q == addr_t'($past(idx_q) + addr_t'(1))));
  // R5: full is sticky
  p_full_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |=> full_q);
  // R5: full rises only from the write of the last entry
  p_full_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> ($past(wr_en_o) && $past(idx_q) == LAST));
  // R6: frozen position and no write while full
  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |=> ($stable(idx_q) && !wr_en_o));
endmodule

// File: rtl/cap_mem.sv
module cap_mem
  import cap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  addr_t wr_addr_i,
  input  byte_t wr_data_i,
  input  addr_t rd_addr_i,
  output byte_t rd_data_o
);
  byte_t store_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        store_q[e] <= '0;
      else if (wr_en_i && wr_addr_i == addr_t'(e))
        store_q[e] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= store_q[rd_addr_i];
  end

  // R7: with no write to the addressed entry, two reads in a row agree
  p_read_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rd_addr_i) && !(wr_en_i && wr_addr_i == rd_addr_i)) |=>
      ##1 ($past(rd_addr_i, 2) != rd_addr_i || $stable(rd_data_o)
           || $past(wr_en_i, 2)));
endmodule

// File: rtl/strobe_capture_buf.sv
module strobe_capture_buf
  import cap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [7:0]       data_i,
  output logic             full_o,
  input  logic [4:0]       rd_addr_i,
  output logic [7:0]       rd_data_o
);
  logic  strobe_sync;
  logic  wr_en;
  addr_t wr_addr;

  cap_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (strobe_i),
    .sync_o  (strobe_sync)
  );

  cap_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .strobe_sync_i (strobe_sync),
    .wr_en_o       (wr_en),
    .wr_addr_o     (wr_addr),
    .full_o        (full_o)
  );

  cap_mem u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  // R6: no write reaches the store while full is shown
  p_no_write_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !wr_en);
  // R8: after full, the position is back at zero (wrap)
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> (wr_addr == '0));
endmodule

// File: tb/tb_strobe_capture_buf.sv
module tb_strobe_capture_buf;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strobe_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       full_o;
  logic [4:0] rd_addr_i = 5'd0;
  logic [7:0] rd_data_o;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] exp_mem [32];

  // {byte seed, strobe-high cycles}
  localparam logic [11:0] VEC [8] = '{
    {8'h11, 4'd1}, {8'hA0, 4'd9}, {8'h3C, 4'd2}, {8'hFF, 4'd15},
    {8'h00, 4'd3}, {8'h81, 4'd1}, {8'h5E, 4'd12}, {8'h72, 4'd4}
  };

  strobe_capture_buf dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .data_i(data_i),
    .full_o(full_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic read_check(input int a, input logic [7:0] expv, input string req);
    @(negedge clk_i) rd_addr_i = 5'(a);
    @(negedge clk_i);
    check(rd_data_o == expv, req, rd_data_o, expv);
  endtask

  // raise strobe with byte d for hold cycles, then a quiet gap
  task automatic pulse(input logic [7:0] d, input int hold);
    @(negedge clk_i);
    strobe_i = 1'b1;
    data_i   = d;
    repeat (hold) @(negedge clk_i);
    strobe_i = 1'b0;
    repeat (5) @(negedge clk_i);
    data_i = 8'hEE;
  endtask

  task automatic do_reset();
    @(negedge clk_i) rst_ni = 1'b0;
    strobe_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    do_reset();
    // R1: reset state
    check(full_o == 1'b0, "R1 full", full_o, 0);
    for (int a = 0; a < 32; a++) read_check(a, 8'h00, "R1 entry");

    // R3/R7: first capture with exact latency and read/write collision on entry 0
    @(negedge clk_i);          // N0: before E0
    rd_addr_i = 5'd0;
    strobe_i  = 1'b1;
    data_i    = 8'h11;
    @(negedge clk_i);          // N1
    @(negedge clk_i);          // N2
    @(negedge clk_i);          // N3: before E3
    data_i = 8'h5A;
    @(negedge clk_i);          // N4: after E3
    data_i = 8'hC3;
    check(rd_data_o == 8'h00, "R7 collision old value", rd_data_o, 0);
    @(negedge clk_i);          // N5
    check(rd_data_o == 8'h5A, "R3 sampled at E3", rd_data_o, 8'h5A);
    strobe_i = 1'b0;
    repeat (4) @(negedge clk_i);
    exp_mem[0] = 8'h5A;

    // R2/R4: table walk for entries 1..30
    for (int k = 1; k < 31; k++) begin
      logic [11:0] v;
      v = VEC[k % 8];
      exp_mem[k] = v[11:4] + 8'(k);
      pulse(exp_mem[k], int'(v[3:0]));
    end
    check(full_o == 1'b0, "R5 not full at 31", full_o, 0);

    // R5: 32nd capture, full edge timing
    exp_mem[31] = 8'h9D;
    @(negedge clk_i);
    strobe_i = 1'b1;
    data_i   = 8'h9D;
    @(negedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);          // N3
    check(full_o == 1'b0, "R5 full before E3", full_o, 0);
    @(negedge clk_i);          // N4
    check(full_o == 1'b1, "R5 full after E3", full_o, 1);
    strobe_i = 1'b0;
    repeat (4) @(negedge clk_i);

    for (int a = 0; a < 32; a++) read_check(a, exp_mem[a], "R4 entry");

    // R6: strobes while full
    for (int j = 0; j < 4; j++) pulse(8'h40 + 8'(j), j + 1);
    check(full_o == 1'b1, "R5 full sticky", full_o, 1);
    for (int a = 0; a < 32; a++) read_check(a, exp_mem[a], "R6 frozen entry");

    // R8: reset clears, capture restarts at entry 0
    do_reset();
    check(full_o == 1'b0, "R8 full cleared", full_o, 0);
    read_check(1, 8'h00, "R8 entry cleared");
    pulse(8'h6B, 3);
    read_check(0, 8'h6B, "R8 restart at 0");
    read_check(1, 8'h00, "R8 entry 1 untouched");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule